// File: doc/BRIEF.md
# Dual-Core Idle-State Power Controller

This block follows the idle level of each of two processor cores and decides when the package as a whole may drop into its deepest sleep. Each core starts in the active level C0. It can step down to a shallow halt level (C1), a stop-grant level (C2), or one of two deep levels (C3, C4) in which its clocks are gated. A core can ask for an idle level in three ways: a halt request, a wait hint that names a target level, or a read of a level register in the I/O space. Before either deep level, the core's first-level cache must be written back. That write-back is a request and acknowledge handshake with outside logic.

Shallow levels stay coherent. A snoop moves the core into a short service sub-state, and the core goes back to the same level once the snoop completes. Deep levels ignore snoops and leave only on an interrupt-class event or on a monitor hit. When both cores sit in C4 and the enhanced deep-sleep configuration bit is set, the controller asks for package deep sleep. It drops that request in the very cycle either core leaves C4. Cache flushing, bus signalling and voltage control are outside the block.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: After a synchronous reset every core reads state code 0 (C0), with clk_en high and flush_req, snoop_svc, stop_ack and pkg_sleep_req all low.
- R2: Each core's 3-bit state field reads 0=C0, 1=C1, 2=C2, 3=C3, 4=C4, 5=snoop service, 6=flushing. Core n occupies bits [3n+2:3n].
- R3: From C0, requests are taken in this priority order: halt first, then a wait hint with a valid level, then a level-register read. Halt enters C1. A wait hint at level 1 enters C1 and at level 2 enters C2. A wait hint at level 3 or 4 enters flushing, targeting C3 or C4. A wait hint at any other level is ignored.
- R4: From C0, a level-register read with select 2 enters C2. Select 3 enters flushing with target C3, and select 4 or 5 enters flushing with target C4. Any other select value is ignored.
- R5: In C1 or C2, an interrupt event returns the core to C0. A monitor event returns it to C0 only if the level was entered through a wait hint. A halt or register-read entry ignores the monitor event.
- R6: In C1 or C2 with no wake, a snoop request moves the core to snoop service, where snoop_svc is high. A snoop-done then returns it to the exact level it left. Wake events are not acted on during snoop service.
- R7: While flushing, flush_req stays high until flush_done, and the core then enters the target deep level. A wake event (interrupt or monitor) during flushing takes priority over flush_done and returns the core to C0.
- R8: In C3 and C4, clk_en is low and snoops have no effect. An interrupt event or a monitor event returns the core to C0, whichever way the level was entered.
- R9: stop_ack pulses high for one cycle when a core is in C2 while stop_clk was high at the entering edge, and again each time this condition newly becomes true. It never pulses with stop_clk low.
- R10: pkg_sleep_req is high exactly when deep_en is high and both cores read C4. It falls in the same cycle that either core leaves C4.
- R11: A reset taken in any state, including flushing, puts the core in C0 at the next edge with flush_req low, and no flush_done is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 2 | Per-core halt request |
| wait_req | input | 2 | Per-core wait-hint request |
| wait_lvl | input | 6 | Per-core wait-hint target level, 3 bits per core |
| io_rd | input | 2 | Per-core level-register read strobe |
| io_sel | input | 6 | Per-core level-register select, 3 bits per core |
| snoop_req | input | 2 | Per-core snoop arrival (bus or peer core) |
| snoop_done | input | 2 | Per-core snoop completion |
| mon_evt | input | 2 | Per-core monitor event |
| irq_evt | input | 2 | Per-core interrupt-class wake (SMI, INIT, NMI, INTR, message) |
| flush_done | input | 2 | Per-core cache write-back completion |
| stop_clk | input | 1 | Shared clock-stop request |
| deep_en | input | 1 | Enhanced deep-sleep configuration enable |
| core_state | output | 6 | Per-core state code, 3 bits per core |
| clk_en | output | 2 | Per-core clock enable |
| flush_req | output | 2 | Per-core cache write-back request |
| snoop_svc | output | 2 | Per-core snoop-service indication |
| stop_ack | output | 2 | Per-core stop-grant acknowledge strobe |
| pkg_sleep_req | output | 1 | Package deep-sleep request |

## Verification
The bench drives the monitor event into a halt-entered C1 and into a register-read C2. A design that does not keep track of how the level was entered would wake the core there. It also lands a wake and a flush_done in the same cycle, where the wrong priority would leave the core stuck in a deep level with no pending wake. Snoops are thrown at C3 and C4, which must stay put, and snoop-done must return to C1 or C2 as appropriate; a single shared return state would send a core to the wrong level. Finally, one core leaves C4 while the other stays, and pkg_sleep_req must fall in that same cycle: a registered package request would lag by one clock.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_C0    = 3'd0,
    ST_C1    = 3'd1,
    ST_C2    = 3'd2,
    ST_C3    = 3'd3,
    ST_C4    = 3'd4,
    ST_SNP   = 3'd5,
    ST_FLUSH = 3'd6
  } idle_st_e;
endpackage

// File: rtl/idle_core_fsm.sv
module idle_core_fsm
  import idle_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_req,
  input  logic             wait_req,
  input  logic [LVL_W-1:0] wait_lvl,
  input  logic             io_rd,
  input  logic [LVL_W-1:0] io_sel,
  input  logic             snoop_req,
  input  logic             snoop_done,
  input  logic             mon_evt,
  input  logic             irq_evt,
  input  logic             flush_done,
  input  logic             stop_clk,
  output logic [ST_W-1:0]  state_o,
  output logic             clk_en,
  output logic             flush_req,
  output logic             snoop_svc,
  output logic             stop_ack
);
  idle_st_e st, nxt, ret, nret, tgt, ntgt;
  logic by_wait, nby_wait;
  logic ack_cond, ack_cond_q, ack_q;
  logic wake, wait_ok, io_ok;

  assign wake    = irq_evt | mon_evt;
  assign wait_ok = wait_req && (wait_lvl >= LVL_W'(1)) && (wait_lvl <= LVL_W'(4));
  assign io_ok   = io_rd && (io_sel >= LVL_W'(2)) && (io_sel <= LVL_W'(5));

  always_comb begin
    nxt      = st;
    nret     = ret;
    ntgt     = tgt;
    nby_wait = by_wait;
    case (st)
      ST_C0: begin
        if (halt_req) begin
          nxt = ST_C1; nby_wait = 1'b0;
        end else if (wait_ok) begin
          nby_wait = 1'b1;
          if (wait_lvl == LVL_W'(1))      nxt = ST_C1;
          else if (wait_lvl == LVL_W'(2)) nxt = ST_C2;
          else begin
            nxt  = ST_FLUSH;
            ntgt = (wait_lvl == LVL_W'(3)) ? ST_C3 : ST_C4;
          end
        end else if (io_ok) begin
          nby_wait = 1'b0;
          if (io_sel == LVL_W'(2)) nxt = ST_C2;
          else begin
            nxt  = ST_FLUSH;
            ntgt = (io_sel == LVL_W'(3)) ? ST_C3 : ST_C4;
          end
        end
      end
      ST_C1, ST_C2: begin
        if (irq_evt || (mon_evt && by_wait)) nxt = ST_C0;
        else if (snoop_req) begin
          nxt  = ST_SNP;
          nret = st;
        end
      end
      ST_SNP:   if (snoop_done) nxt = ret;
      ST_FLUSH: begin
        if (wake)            nxt = ST_C0;
        else if (flush_done) nxt = tgt;
      end
      ST_C3, ST_C4: if (wake) nxt = ST_C0;
      default: nxt = ST_C0;
    endcase
  end

  assign ack_cond = (nxt == ST_C2) && stop_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_C0;
      ret        <= ST_C1;
      tgt        <= ST_C3;
      by_wait    <= 1'b0;
      ack_cond_q <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      st         <= nxt;
      ret        <= nret;
      tgt        <= ntgt;
      by_wait    <= nby_wait;
      ack_cond_q <= ack_cond;
      ack_q      <= ack_cond && !ack_cond_q;
    end
  end

  assign state_o   = st;
  assign clk_en    = !((st == ST_C3) || (st == ST_C4));
  assign flush_req = (st == ST_FLUSH);
  assign snoop_svc = (st == ST_SNP);
  assign stop_ack  = ack_q;

  // R5: a halt-entered C1 ignores a lone monitor event
  a_r5_halt_ignores_monitor: assert property (@(posedge clk) disable iff (rst)
    (st == ST_C1 && !by_wait && mon_evt && !irq_evt && !snoop_req) |=> (st == ST_C1));

  // R6: snoop service returns to the level it left
  a_r6_snoop_return: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SNP && snoop_done) |=> (st == $past(ret)));

  // R7: flushing holds until done or a wake
  a_r7_flush_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FLUSH && !flush_done && !wake) |=> (st == ST_FLUSH && flush_req));

  // R8: deep levels ignore snoops
  a_r8_deep_stays: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_C3 || st == ST_C4) && !wake) |=> $stable(st));

  // R9: stop-grant acknowledge is a single-cycle strobe
  a_r9_ack_strobe: assert property (@(posedge clk) disable iff (rst)
    stop_ack |=> !stop_ack);
endmodule

// File: rtl/idle_pkg_sleep.sv
module idle_pkg_sleep
  import idle_pkg::*;
#(
  parameter int NCORES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCORES*ST_W-1:0] states,
  input  logic                   deep_en,
  output logic                   pkg_req
);
  logic [NCORES-1:0] in_c4;

  for (genvar i = 0; i < NCORES; i++) begin : g_c4
    assign in_c4[i] = (states[i*ST_W +: ST_W] == ST_C4);
  end

  assign pkg_req = deep_en && (&in_c4);

  // R10: request drops no later than the cycle a core leaves C4
  a_r10_pkg_drop: assert property (@(posedge clk) disable iff (rst)
    (pkg_req && !(&in_c4)) |-> 1'b0);
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
  import idle_pkg::*;
#(
  parameter int NCORES = 2,
  parameter int LVL_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCORES-1:0]       halt_req,
  input  logic [NCORES-1:0]       wait_req,
  input  logic [NCORES*LVL_W-1:0] wait_lvl,
  input  logic [NCORES-1:0]       io_rd,
  input  logic [NCORES*LVL_W-1:0] io_sel,
  input  logic [NCORES-1:0]       snoop_req,
  input  logic [NCORES-1:0]       snoop_done,
  input  logic [NCORES-1:0]       mon_evt,
  input  logic [NCORES-1:0]       irq_evt,
  input  logic [NCORES-1:0]       flush_done,
  input  logic                    stop_clk,
  input  logic                    deep_en,
  output logic [NCORES*ST_W-1:0]  core_state,
  output logic [NCORES-1:0]       clk_en,
  output logic [NCORES-1:0]       flush_req,
  output logic [NCORES-1:0]       snoop_svc,
  output logic [NCORES-1:0]       stop_ack,
  output logic                    pkg_sleep_req
);
  for (genvar i = 0; i < NCORES; i++) begin : g_core
    idle_core_fsm #(.LVL_W(LVL_W)) u_core (
      .clk        (clk),
      .rst        (rst),
      .halt_req   (halt_req[i]),
      .wait_req   (wait_req[i]),
      .wait_lvl   (wait_lvl[i*LVL_W +: LVL_W]),
      .io_rd      (io_rd[i]),
      .io_sel     (io_sel[i*LVL_W +: LVL_W]),
      .snoop_req  (snoop_req[i]),
      .snoop_done (snoop_done[i]),
      .mon_evt    (mon_evt[i]),
      .irq_evt    (irq_evt[i]),
      .flush_done (flush_done[i]),
      .stop_clk   (stop_clk),
      .state_o    (core_state[i*ST_W +: ST_W]),
      .clk_en     (clk_en[i]),
      .flush_req  (flush_req[i]),
      .snoop_svc  (snoop_svc[i]),
      .stop_ack   (stop_ack[i])
    );
  end

  idle_pkg_sleep #(.NCORES(NCORES)) u_pkg (
    .clk     (clk),
    .rst     (rst),
    .states  (core_state),
    .deep_en (deep_en),
    .pkg_req (pkg_sleep_req)
  );
endmodule

// File: tb/idle_pwr_ctrl_test.sv
module idle_pwr_ctrl_test;
  logic clk = 1'b0;
  logic rst;
  logic [1:0] halt_req, wait_req, io_rd, snoop_req, snoop_done, mon_evt, irq_evt, flush_done;
  logic [5:0] wait_lvl, io_sel;
  logic stop_clk, deep_en;
  logic [5:0] core_state;
  logic [1:0] clk_en, flush_req, snoop_svc, stop_ack;
  logic pkg_sleep_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state per core
  int m_st[2], m_ret[2], m_tgt[2], m_bw[2], m_cq[2], m_ack[2];
  string m_tag[2];

  always #2.5 clk = ~clk;

  idle_pwr_ctrl uut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .wait_req(wait_req), .wait_lvl(wait_lvl),
    .io_rd(io_rd), .io_sel(io_sel), .snoop_req(snoop_req), .snoop_done(snoop_done),
    .mon_evt(mon_evt), .irq_evt(irq_evt), .flush_done(flush_done), .stop_clk(stop_clk),
    .deep_en(deep_en), .core_state(core_state), .clk_en(clk_en), .flush_req(flush_req),
    .snoop_svc(snoop_svc), .stop_ack(stop_ack), .pkg_sleep_req(pkg_sleep_req)
  );

  task automatic clear_in();
    rst = 0; halt_req = 0; wait_req = 0; io_rd = 0; snoop_req = 0; snoop_done = 0;
    mon_evt = 0; irq_evt = 0; flush_done = 0; wait_lvl = 0; io_sel = 0;
  endtask

  function automatic int next_st(int i, output int nret, output int ntgt, output int nbw,
                                 output string tag);
    int s = m_st[i];
    int wl = int'(wait_lvl[i*3 +: 3]);
    int sl = int'(io_sel[i*3 +: 3]);
    bit wk = irq_evt[i] | mon_evt[i];
    nret = m_ret[i]; ntgt = m_tgt[i]; nbw = m_bw[i];
    tag = "R2";
    if (rst) begin
      tag = "R11"; nret = 1; ntgt = 3; nbw = 0; return 0;
    end
    case (s)
      0: begin
        tag = "R3";
        if (halt_req[i]) begin nbw = 0; return 1; end
        if (wait_req[i] && wl >= 1 && wl <= 4) begin
          nbw = 1;
          if (wl <= 2) return wl;
          ntgt = wl; return 6;
        end
        if (io_rd[i] && sl >= 2 && sl <= 5) begin
          tag = "R4"; nbw = 0;
          if (sl == 2) return 2;
          ntgt = (sl == 3) ? 3 : 4; return 6;
        end
        return 0;
      end
      1, 2: begin
        tag = "R5";
        if (irq_evt[i] || (mon_evt[i] && m_bw[i] != 0)) return 0;
        if (snoop_req[i]) begin tag = "R6"; nret = s; return 5; end
        return s;
      end
      5: begin tag = "R6"; return snoop_done[i] ? m_ret[i] : 5; end
      6: begin tag = "R7"; if (wk) return 0; return flush_done[i] ? m_tgt[i] : 6; end
      default: begin tag = "R8"; return wk ? 0 : s; end
    endcase
  endfunction

  task automatic chk(string tag, string what, int i, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s core%0d %s: got %0d expected %0d", tag, i, what, act, exp);
    end
  endtask

  // inputs are already applied; advance model, wait one edge, compare
  task automatic step(string force_tag = "");
    int ns[2], nr[2], nt[2], nb[2];
    string tg[2];
    bit c4both;
    for (int i = 0; i < 2; i++) begin
      ns[i] = next_st(i, nr[i], nt[i], nb[i], tg[i]);
      if (force_tag != "") tg[i] = force_tag;
    end
    for (int i = 0; i < 2; i++) begin
      int nc = (!rst && ns[i] == 2 && stop_clk) ? 1 : 0;
      m_ack[i] = rst ? 0 : ((nc != 0 && m_cq[i] == 0) ? 1 : 0);
      m_cq[i]  = rst ? 0 : nc;
      m_st[i] = ns[i]; m_ret[i] = nr[i]; m_tgt[i] = nt[i]; m_bw[i] = nb[i]; m_tag[i] = tg[i];
    end
    @(negedge clk);
    c4both = (m_st[0] == 4) && (m_st[1] == 4);
    for (int i = 0; i < 2; i++) begin
      chk({m_tag[i], "/R2"}, "state", i, int'(core_state[i*3 +: 3]), m_st[i]);
      chk((force_tag != "") ? force_tag : "R8", "clk_en", i, int'(clk_en[i]),
          (m_st[i] == 3 || m_st[i] == 4) ? 0 : 1);
      chk((force_tag != "") ? force_tag : "R7", "flush_req", i, int'(flush_req[i]),
          (m_st[i] == 6) ? 1 : 0);
      chk((force_tag != "") ? force_tag : "R6", "snoop_svc", i, int'(snoop_svc[i]),
          (m_st[i] == 5) ? 1 : 0);
      chk((force_tag != "") ? force_tag : "R9", "stop_ack", i, int'(stop_ack[i]), m_ack[i]);
    end
    chk((force_tag != "") ? force_tag : "R10", "pkg_sleep_req", 0, int'(pkg_sleep_req),
        (deep_en && c4both) ? 1 : 0);
  endtask

  task automatic do_reset(string tag);
    clear_in(); rst = 1; step(tag); rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin
      m_st[i] = 0; m_ret[i] = 1; m_tgt[i] = 3; m_bw[i] = 0; m_cq[i] = 0; m_ack[i] = 0;
    end
    clear_in(); stop_clk = 0; deep_en = 1;
    @(negedge clk);
    do_reset("R1");
    do_reset("R1");

    // R5: halt-entered C1 ignores monitor; wait-entered C1 wakes on it
    clear_in(); halt_req = 2'b01; wait_req = 2'b10; wait_lvl = 6'b001_000; step();
    clear_in(); mon_evt = 2'b11; step();
    clear_in(); irq_evt = 2'b01; step();

    // R4/R7: register read select 3 flushes; wake and done together abort (R7)
    clear_in(); io_rd = 2'b11; io_sel = 6'b011_011; step();
    clear_in(); step();
    clear_in(); flush_done = 2'b11; irq_evt = 2'b01; step();

    // R8: core1 in C3 ignores snoops, wakes on monitor
    clear_in(); snoop_req = 2'b10; step();
    clear_in(); mon_evt = 2'b10; step();

    // R10: both to C4 (select 5 and wait level 4), then one leaves
    clear_in(); io_rd = 2'b01; io_sel = 6'b000_101; wait_req = 2'b10; wait_lvl = 6'b100_000; step();
    clear_in(); flush_done = 2'b11; step();
    clear_in(); snoop_req = 2'b11; step();
    clear_in(); deep_en = 0; step();
    clear_in(); deep_en = 1; step();
    clear_in(); irq_evt = 2'b10; step();
    clear_in(); irq_evt = 2'b01; step();

    // R6/R9: C2 with stop_clk, snoop round trip, ack again on return
    clear_in(); stop_clk = 1; wait_req = 2'b01; wait_lvl = 6'b000_010; step();
    clear_in(); snoop_req = 2'b01; step();
    clear_in(); snoop_done = 2'b01; step();
    clear_in(); step();
    stop_clk = 0; irq_evt = 2'b01; step();

    // R11: reset from flushing
    clear_in(); wait_req = 2'b01; wait_lvl = 6'b000_011; step();
    do_reset("R11");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      clear_in();
      for (int i = 0; i < 2; i++) begin
        halt_req[i]   = ($urandom % 16) == 0;
        wait_req[i]   = ($urandom % 10) == 0;
        wait_lvl[i*3 +: 3] = 3'($urandom % 6);
        io_rd[i]      = ($urandom % 10) == 0;
        io_sel[i*3 +: 3] = 3'($urandom % 7);
        snoop_req[i]  = ($urandom % 4) == 0;
        snoop_done[i] = ($urandom % 3) == 0;
        mon_evt[i]    = ($urandom % 24) == 0;
        irq_evt[i]    = ($urandom % 24) == 0;
        flush_done[i] = ($urandom % 4) == 0;
      end
      if (($urandom % 8) == 0) stop_clk = ~stop_clk;
      deep_en = ($urandom % 8) != 0;
      rst = ($urandom % 250) == 0;
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule